// File: doc/BRIEF.md
# Multiplexed Parallel I/O Controller

This block manages a bank of 32 I/O lines. Each line is driven either by the controller itself, acting as a general-purpose pin with its own output-enable and output-data bits, or by a peripheral signal that is routed through to the pad. The lowest six lines have no peripheral behind them and always stay general purpose. Whichever side owns a line, its input is always sampled. The sampled value can pass through an optional per-pin glitch filter. Any level change on the resulting value is recorded in a change-status register and can raise an interrupt.

Software reaches the block through a simple word-addressed bus. Each control group has three addresses: a write-one-to-set address, a write-one-to-clear address and a read address. A bit can therefore be changed without a read-modify-write. Read data comes back one cycle after the read strobe. Reading the change-status register clears it.

Each pin's input path runs through a two-flop synchroniser and then a small per-pin state machine with two states. In state SETTLED the filtered level matches the synchronised input. A mismatch does one of two things:
- with the filter off, the level is copied at once (SETTLED to SETTLED);
- with the filter on, the machine moves to PENDING (SETTLED to PENDING).

In PENDING, the level is copied if the mismatch is still present one sample later (PENDING to SETTLED, accept). Otherwise the pulse is dropped (PENDING to SETTLED, reject).

Top module: `pio_mux`

## Requirements
- R1: After reset, every control register and the change status read as 0, pad_oe and pad_out are 0, and irq is 0.
- R2: The address map is as follows. Bits addr[4:2] select the group: 0 peripheral select, 1 output enable, 2 output data, 3 filter enable, 4 interrupt enable. Bits addr[1:0] select the operation: 0 sets the bits written as 1, 1 clears the bits written as 1, 2 reads the group. Other bits are unchanged. A read presents bus_rdata with bus_rvalid high in the cycle after the bus_rd cycle.
- R3: Peripheral-select bits 0 to 5 always read 0, and writes to them are ignored. Those pads always follow the general-purpose registers.
- R4: A line with peripheral select 1 drives pad_out and pad_oe from per_out and per_oe. A line with peripheral select 0 drives them from the output-data and output-enable registers.
- R5: Address 0x14 reads the filtered input level of all 32 lines, whoever owns each line.
- R6: A pad change applied before clock edge E1 reaches the change status at edge E4 when the filter is off, and at edge E5 when the filter is on.
- R7: With the filter on, an input pulse that lasts one clock sample leaves no trace in level or status. A pulse of two samples passes. With the filter off, a one-sample pulse is recorded.
- R8: A status bit is set by a rising or a falling edge of the filtered level. Reading address 0x15 returns the status and clears it. An edge in the same cycle as the read stays set.
- R9: irq is high exactly when some change-status bit and its interrupt-enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| per_out | input | 32 | Peripheral output values |
| per_oe | input | 32 | Peripheral output enables |
| pad_in | input | 32 | Raw pad inputs |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| irq | output | 1 | Interrupt request |

## Verification
The bench times the interrupt edge by edge, with the filter off and with it on. A design with one flop too many or too few in the input path raises irq one cycle off and is reported. Single-sample glitches are sent with the filter on, where a weak filter would log a change, and with the filter off, where an over-eager filter would hide one. The bench also tries to set peripheral select on the six dedicated lines, which would hand those pads to per_out. It checks that a status read clears the bits, so a design that never clears would hold irq high.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int ADDR_W   = 5;
    localparam int NUM_GRP  = 5;
    localparam logic [2:0] GRP_PSEL = 3'd0;
    localparam logic [2:0] GRP_OE   = 3'd1;
    localparam logic [2:0] GRP_DOUT = 3'd2;
    localparam logic [2:0] GRP_FEN  = 3'd3;
    localparam logic [2:0] GRP_IEN  = 3'd4;
    localparam logic [1:0] OP_SET   = 2'd0;
    localparam logic [1:0] OP_CLR   = 2'd1;
    localparam logic [1:0] OP_READ  = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_LEVEL = 5'h14;
    localparam logic [ADDR_W-1:0] ADDR_CHG   = 5'h15;

    typedef enum logic {
        FS_SETTLED = 1'b0,
        FS_PENDING = 1'b1
    } filt_state_e;
endpackage

// File: rtl/pio_pin_filter.sv
module pio_pin_filter
    import pio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic filt_en,
    input  logic pad_i,
    output logic lvl_o
);
    logic        sync1, sync2;
    logic        lvl, lvl_nxt;
    filt_state_e st, st_nxt;

    // State register, synchroniser and level register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            st    <= FS_SETTLED;
            lvl   <= 1'b0;
        end else begin
            sync1 <= pad_i;
            sync2 <= sync1;
            st    <= st_nxt;
            lvl   <= lvl_nxt;
        end
    end

    // Transition and output logic
    always_comb begin
        st_nxt  = st;
        lvl_nxt = lvl;
        unique case (st)
            FS_SETTLED: begin
                if (sync2 != lvl) begin
                    if (filt_en) st_nxt  = FS_PENDING;
                    else         lvl_nxt = sync2;
                end
            end
            FS_PENDING: begin
                st_nxt = FS_SETTLED;
                if (sync2 != lvl) lvl_nxt = sync2;
            end
            default: st_nxt = FS_SETTLED;
        endcase
    end

    assign lvl_o = lvl;

    // R7
    filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_en && st == FS_SETTLED) |=> $stable(lvl));

    // R6
    nofilt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!filt_en && st == FS_SETTLED && sync2 != lvl) |=> (lvl == $past(sync2)));
endmodule

// File: rtl/pio_regs.sv
module pio_regs
    import pio_pkg::*;
#(
    parameter int NUM_LINES   = 32,
    parameter int NUM_GP_ONLY = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [NUM_LINES-1:0] bus_wdata,
    input  logic [NUM_LINES-1:0] lvl,
    input  logic [NUM_LINES-1:0] chg_stat,
    output logic [NUM_LINES-1:0] psel,
    output logic [NUM_LINES-1:0] oe,
    output logic [NUM_LINES-1:0] dout,
    output logic [NUM_LINES-1:0] fen,
    output logic [NUM_LINES-1:0] ien,
    output logic [NUM_LINES-1:0] rdata,
    output logic                 rvalid,
    output logic                 stat_clr
);
    localparam logic [NUM_LINES-1:0] DED_MASK = (NUM_LINES)'((64'd1 << NUM_GP_ONLY) - 64'd1);

    logic [NUM_LINES-1:0] ctl [NUM_GRP];
    logic [2:0]           grp;
    logic [1:0]           op;
    logic [NUM_LINES-1:0] rd_mux;

    assign grp = bus_addr[4:2];
    assign op  = bus_addr[1:0];

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam logic [NUM_LINES-1:0] WMASK = (g == 0) ? ~DED_MASK : '1;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctl[g] <= '0;
            end else if (bus_wr && grp == 3'(g)) begin
                if (op == OP_SET)      ctl[g] <= ctl[g] | (bus_wdata & WMASK);
                else if (op == OP_CLR) ctl[g] <= ctl[g] & ~bus_wdata;
            end
        end
    end

    assign psel = ctl[GRP_PSEL];
    assign oe   = ctl[GRP_OE];
    assign dout = ctl[GRP_DOUT];
    assign fen  = ctl[GRP_FEN];
    assign ien  = ctl[GRP_IEN];

    always_comb begin
        rd_mux = '0;
        if (bus_addr == ADDR_LEVEL)     rd_mux = lvl;
        else if (bus_addr == ADDR_CHG)  rd_mux = chg_stat;
        else if (op == OP_READ && grp < 3'(NUM_GRP)) begin
            unique case (grp)
                GRP_PSEL: rd_mux = ctl[GRP_PSEL];
                GRP_OE:   rd_mux = ctl[GRP_OE];
                GRP_DOUT: rd_mux = ctl[GRP_DOUT];
                GRP_FEN:  rd_mux = ctl[GRP_FEN];
                default:  rd_mux = ctl[GRP_IEN];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= bus_rd;
            if (bus_rd) rdata <= rd_mux;
        end
    end

    assign stat_clr = bus_rd && (bus_addr == ADDR_CHG);

    // R2
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> rvalid);

    // R3
    ded_psel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> ((psel & DED_MASK) == '0));
endmodule

// File: rtl/pio_change.sv
module pio_change #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] lvl,
    input  logic                 stat_clr,
    input  logic [NUM_LINES-1:0] ien,
    output logic [NUM_LINES-1:0] stat,
    output logic                 irq
);
    logic [NUM_LINES-1:0] lvl_q;
    logic [NUM_LINES-1:0] edge_v;

    assign edge_v = lvl ^ lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
            stat  <= '0;
        end else begin
            lvl_q <= lvl;
            stat  <= (stat & ~{NUM_LINES{stat_clr}}) | edge_v;
        end
    end

    assign irq = |(stat & ien);

    // R8
    edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_v) |=> ((stat & $past(edge_v)) == $past(edge_v)));

    // R8
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr |=> ((stat & ~$past(edge_v)) == '0));
endmodule

// File: rtl/pio_mux.sv
module pio_mux
    import pio_pkg::*;
#(
    parameter int NUM_LINES   = 32,
    parameter int NUM_GP_ONLY = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [4:0]           bus_addr,
    input  logic [NUM_LINES-1:0] bus_wdata,
    output logic [NUM_LINES-1:0] bus_rdata,
    output logic                 bus_rvalid,
    input  logic [NUM_LINES-1:0] per_out,
    input  logic [NUM_LINES-1:0] per_oe,
    input  logic [NUM_LINES-1:0] pad_in,
    output logic [NUM_LINES-1:0] pad_out,
    output logic [NUM_LINES-1:0] pad_oe,
    output logic                 irq
);
    logic [NUM_LINES-1:0] psel, oe, dout, fen, ien, lvl, stat;
    logic                 stat_clr;

    pio_regs #(.NUM_LINES(NUM_LINES), .NUM_GP_ONLY(NUM_GP_ONLY)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .lvl(lvl), .chg_stat(stat),
        .psel(psel), .oe(oe), .dout(dout), .fen(fen), .ien(ien),
        .rdata(bus_rdata), .rvalid(bus_rvalid), .stat_clr(stat_clr)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_pin
        pio_pin_filter u_filt (
            .clk(clk), .rst_n(rst_n), .filt_en(fen[i]),
            .pad_i(pad_in[i]), .lvl_o(lvl[i])
        );
        assign pad_out[i] = psel[i] ? per_out[i] : dout[i];
        assign pad_oe[i]  = psel[i] ? per_oe[i]  : oe[i];
    end

    pio_change #(.NUM_LINES(NUM_LINES)) u_chg (
        .clk(clk), .rst_n(rst_n), .lvl(lvl), .stat_clr(stat_clr),
        .ien(ien), .stat(stat), .irq(irq)
    );

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq);
endmodule

// File: tb/sim_pio_mux.sv
module sim_pio_mux;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [31:0] per_out = '0, per_oe = '0, pad_in = '0;
    logic [31:0] pad_out, pad_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    pio_mux u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .per_out(per_out), .per_oe(per_oe),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // driver: push expected read result, then strobe the read
    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string req);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        @(negedge clk);
    endtask

    // monitor: compare every returned read against the scoreboard
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R2: unexpected read data %h expected none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin : watchdog
        #2000000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        check("R1 pad_oe", pad_oe, 32'h0);
        check("R1 pad_out", pad_out, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        rd(5'h02, 32'h0, "R1 psel");
        rd(5'h06, 32'h0, "R1 oe");
        rd(5'h0A, 32'h0, "R1 dout");
        rd(5'h0E, 32'h0, "R1 fen");
        rd(5'h12, 32'h0, "R1 ien");
        rd(5'h15, 32'h0, "R1 chg");

        // R2 set/clear
        wr(5'h04, 32'hFF00FF00);
        wr(5'h05, 32'h0F000F00);
        rd(5'h06, 32'hF000F000, "R2 oe set/clr");
        wr(5'h08, 32'hA5A5A5A5);
        check("R4 gpio pad_out", pad_out, 32'hA5A5A5A5);
        check("R4 gpio pad_oe", pad_oe, 32'hF000F000);

        // R3 dedicated lines / R4 ownership
        per_out = 32'h5A5A5A5A; per_oe = 32'hFFFFFFFF;
        wr(5'h00, 32'hFFFFFFFF);
        rd(5'h02, 32'hFFFFFFC0, "R3 psel low bits");
        check("R4 periph pad_out", pad_out, (32'h5A5A5A5A & 32'hFFFFFFC0) | (32'hA5A5A5A5 & 32'h3F));
        check("R3 ded pad_oe", pad_oe, 32'hFFFFFFC0 | (32'hF000F000 & 32'h3F));
        wr(5'h01, 32'h0000FFFF);
        rd(5'h02, 32'hFFFF0000, "R2 psel clr");

        // R5 input level with mixed ownership, R8 both edges
        pad_in = 32'h12345678;
        step(6);
        rd(5'h14, 32'h12345678, "R5 level");
        rd(5'h15, 32'h12345678, "R8 rising edges");
        rd(5'h15, 32'h0, "R8 cleared on read");
        pad_in = 32'h0;
        step(6);
        rd(5'h15, 32'h12345678, "R8 falling edges");

        // R6 / R9 unfiltered latency and irq
        wr(5'h10, 32'h00000001);
        pad_in[0] = 1'b1;
        step(3);
        check("R6 nofilt not yet", {31'h0, irq}, 32'h0);
        step(1);
        check("R6 nofilt at E4", {31'h0, irq}, 32'h1);
        rd(5'h15, 32'h1, "R9 status");
        check("R9 irq after clear", {31'h0, irq}, 32'h0);
        pad_in[2] = 1'b1;
        step(6);
        check("R9 masked pin", {31'h0, irq}, 32'h0);
        rd(5'h15, 32'h4, "R9 masked status");

        // R6 filtered latency
        wr(5'h0C, 32'h00000001);
        pad_in[0] = 1'b0;
        step(4);
        check("R6 filt not yet", {31'h0, irq}, 32'h0);
        step(1);
        check("R6 filt at E5", {31'h0, irq}, 32'h1);
        rd(5'h15, 32'h1, "R6 filt status");

        // R7 glitches: pin0 filtered, pin1 unfiltered
        pad_in[0] = 1'b1; pad_in[1] = 1'b1;
        step(1);
        pad_in[0] = 1'b0; pad_in[1] = 1'b0;
        step(8);
        check("R7 glitch rejected irq", {31'h0, irq}, 32'h0);
        rd(5'h15, 32'h2, "R7 glitch status");
        pad_in[0] = 1'b1;
        step(2);
        pad_in[0] = 1'b0;
        step(8);
        rd(5'h15, 32'h1, "R7 two-sample pulse");

        step(2);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R2: actual %0d pending reads expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule